// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for each access presented to it, whether the access skips the paging walk because it falls in a transparent translation window. It keeps three banks of window registers. Each bank holds `NUM_WIN` windows. The classic bank compares the top address byte, the function code and the transfer direction, each under its own mask. The two compact banks hold the data windows and the instruction windows. A compact window compares the top address byte under a mask, selects a privilege match through a 2-bit field, and can mark the window write-protected.

A request carries an address, a 3-bit function code, a read/write flag and a format select. One cycle after a request strobe, the block reports:

- whether a window hit;
- which window won;
- a 16-bit status word;
- for the compact format, a write-protect fault.

Windows are loaded through a plain write port.

Top module: `ttw_matcher`

## Requirements
- R1: After reset every window register is zero (disabled), and `rsp_valid`, `rsp_hit`, `rsp_win`, `rsp_fault` and `rsp_status` are all zero.
- R2: A write with `wr_en` high loads `wr_data` into a window register. The selector codes are: 0 and 1 for classic windows 0 and 1, 2 and 3 for data windows 0 and 1, 4 and 5 for instruction windows 0 and 1. Codes 6 and 7 change nothing. A request in the same cycle as a write still sees the old value.
- R3: `rsp_valid` equals `req_valid` delayed by one cycle. Result outputs update only on the edge that captures a request; without a strobe they hold their values.
- R4: In either format, a window whose register bit 15 is clear never matches.
- R5: Address compare, in both formats: register bits 31:24 are the base for address bits 31:24. A 1 in register bits 23:16 makes the corresponding address bit a don't-care.
- R6: Classic function-code compare: register bits 6:4 are the expected function code. A 1 in register bits 2:0 makes that function-code bit a don't-care.
- R7: Classic direction compare: when register bit 8 is set, the direction is ignored. Otherwise `req_rd` (1 = read) must equal register bit 9.
- R8: On a hit, `rsp_status` is 0x0040 (transparent bit 6). On a fault it is 0x8000 (bit 15). Otherwise it is 0.
- R9: When several windows of the selected set match, the lowest-numbered one wins and is reported on `rsp_win`. With no match, `rsp_win` is 0.
- R10: In the compact format, function-code bit 0 set selects the data windows. Otherwise, bit 1 set selects the instruction windows. With both bits clear, nothing matches.
- R11: Compact privilege field, register bits 14:13:
  - 0 matches only user accesses (function-code bit 2 clear);
  - 1 matches only supervisor accesses;
  - 2 and 3 match either.
- R12: A compact write (`req_rd`=0) whose winning window has register bit 2 set gives `rsp_fault`=1 and `rsp_hit`=0. Reads never fault, and the classic format never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Window register write strobe |
| wr_sel | input | 3 | Window register selector |
| wr_data | input | 32 | Value to load |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 1 | 0 = classic windows, 1 = compact windows |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code (bit 2 supervisor, bit 1 program, bit 0 data) |
| req_rd | input | 1 | 1 = read, 0 = write |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Access passes through a window |
| rsp_win | output | 1 | Index of the winning window |
| rsp_status | output | 16 | Status word |
| rsp_fault | output | 1 | Write-protect fault |

## Verification
The bench builds the block with its defaults: two windows per bank and a 32-bit address. Since only the top address byte is compared, this configuration allows a full sweep of every top-byte value against every function code and both directions, for each register setup.

The setups cover:
- disabled windows that would otherwise match everything;
- partial masks on address and function code;
- direction-qualified windows;
- overlapping windows, which exercise priority;
- every privilege mode;
- write-protected compact windows shadowed by, or shadowing, unprotected ones.

Directed steps cover a write and a request in the same cycle, the unused selector codes, and output hold between strobes.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  localparam int REG_W  = 32;
  localparam int FC_W   = 3;
  localparam int BYTE_W = 8;

  // window register field positions
  localparam int F_EN      = 15;
  localparam int F_BASE_LO = 24;
  localparam int F_MASK_LO = 16;
  localparam int F_RW_IGN  = 8;
  localparam int F_RW_VAL  = 9;
  localparam int F_FCB_LO  = 4;
  localparam int F_FCM_LO  = 0;
  localparam int F_MODE_LO = 13;
  localparam int F_WP      = 2;

  typedef enum logic {
    FMT_CLASSIC = 1'b0,
    FMT_COMPACT = 1'b1
  } ttw_fmt_e;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_ANY_A = 2'd2,
    PRV_ANY_B = 2'd3
  } ttw_prv_e;

  // top address byte compare, mask bit 1 = don't care
  function automatic logic addr_in_window(input logic [REG_W-1:0] cfg,
                                          input logic [BYTE_W-1:0] addr_hi);
    logic [BYTE_W-1:0] care;
    care = ~cfg[F_MASK_LO +: BYTE_W];
    return ((addr_hi ^ cfg[F_BASE_LO +: BYTE_W]) & care) == '0;
  endfunction
endpackage

// File: rtl/ttw_regfile.sv
module ttw_regfile
  import ttw_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int SEL_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [REG_W-1:0]              wr_data,
  output logic [NUM_WIN-1:0][REG_W-1:0] cls_q,
  output logic [NUM_WIN-1:0][REG_W-1:0] dat_q,
  output logic [NUM_WIN-1:0][REG_W-1:0] ins_q
);
  localparam int NUM_BANK = 3;

  logic [NUM_BANK-1:0][NUM_WIN-1:0][REG_W-1:0] bank_q;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic             load;
      logic [REG_W-1:0] cfg_r;

      assign load = wr_en && (wr_sel == SEL_W'(b * NUM_WIN + i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_r <= '0;
        end else if (load) begin
          cfg_r <= wr_data;
        end
      end

      assign bank_q[b][i] = cfg_r;
    end
  end

  assign cls_q = bank_q[0];
  assign dat_q = bank_q[1];
  assign ins_q = bank_q[2];
endmodule

// File: rtl/ttw_win_classic.sv
module ttw_win_classic
  import ttw_pkg::*;
(
  input  logic [REG_W-1:0]  cfg,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic [FC_W-1:0]   fc,
  input  logic              rd,
  output logic              match
);
  logic            addr_ok;
  logic            fc_ok;
  logic            rw_ok;
  logic [FC_W-1:0] fc_care;
  logic            unused_cfg;

  assign unused_cfg = ^{cfg[14:10], cfg[7], cfg[3]};

  assign addr_ok = addr_in_window(cfg, addr_hi);
  assign fc_care = ~cfg[F_FCM_LO +: FC_W];
  assign fc_ok   = ((fc ^ cfg[F_FCB_LO +: FC_W]) & fc_care) == '0;
  assign rw_ok   = cfg[F_RW_IGN] | (rd == cfg[F_RW_VAL]);
  assign match   = cfg[F_EN] & addr_ok & fc_ok & rw_ok;
endmodule

// File: rtl/ttw_win_compact.sv
module ttw_win_compact
  import ttw_pkg::*;
(
  input  logic [REG_W-1:0]  cfg,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic              super_acc,
  output logic              match,
  output logic              wprot
);
  ttw_prv_e mode;
  logic     prv_ok;
  logic     unused_cfg;

  assign unused_cfg = ^{cfg[12:3], cfg[1:0]};
  assign mode       = ttw_prv_e'(cfg[F_MODE_LO +: 2]);

  always_comb begin
    case (mode)
      PRV_USER:  prv_ok = !super_acc;
      PRV_SUPER: prv_ok = super_acc;
      default:   prv_ok = 1'b1;
    endcase
  end

  assign match = cfg[F_EN] & addr_in_window(cfg, addr_hi) & prv_ok;
  assign wprot = cfg[F_WP];
endmodule

// File: rtl/ttw_prio.sv
module ttw_prio #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
  import ttw_pkg::*;
#(
  parameter int NUM_WIN  = 2,
  parameter int ADDR_W   = 32,
  parameter int ST_W     = 16,
  parameter int ST_TRANS = 6,
  parameter int ST_BERR  = 15,
  localparam int SEL_W   = $clog2(3 * NUM_WIN),
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic              req_fmt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [FC_W-1:0]   req_fc,
  input  logic              req_rd,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [ST_W-1:0]   rsp_status,
  output logic              rsp_fault
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe[1];

  // window registers
  logic [NUM_WIN-1:0][REG_W-1:0] cls_q, dat_q, ins_q;

  ttw_regfile #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_ns),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .cls_q  (cls_q),
    .dat_q  (dat_q),
    .ins_q  (ins_q)
  );

  // per-window compare
  logic [BYTE_W-1:0]  addr_hi;
  logic               unused_addr_lo;
  logic [NUM_WIN-1:0] cls_hit, dat_hit, dat_wp, ins_hit, ins_wp;

  assign addr_hi        = req_addr[ADDR_W-1 -: BYTE_W];
  assign unused_addr_lo = ^req_addr[ADDR_W-BYTE_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ttw_win_classic u_cls (
      .cfg    (cls_q[w]),
      .addr_hi(addr_hi),
      .fc     (req_fc),
      .rd     (req_rd),
      .match  (cls_hit[w])
    );
    ttw_win_compact u_dat (
      .cfg      (dat_q[w]),
      .addr_hi  (addr_hi),
      .super_acc(req_fc[2]),
      .match    (dat_hit[w]),
      .wprot    (dat_wp[w])
    );
    ttw_win_compact u_ins (
      .cfg      (ins_q[w]),
      .addr_hi  (addr_hi),
      .super_acc(req_fc[2]),
      .match    (ins_hit[w]),
      .wprot    (ins_wp[w])
    );
  end

  // compact pair select: data access first, then program access
  logic [NUM_WIN-1:0] cmp_hit, cmp_wp;

  always_comb begin
    cmp_hit = '0;
    cmp_wp  = '0;
    if (req_fc[0]) begin
      cmp_hit = dat_hit;
      cmp_wp  = dat_wp;
    end else if (req_fc[1]) begin
      cmp_hit = ins_hit;
      cmp_wp  = ins_wp;
    end
  end

  logic             cls_any, cmp_any;
  logic [IDX_W-1:0] cls_idx, cmp_idx;

  ttw_prio #(.N(NUM_WIN), .IDX_W(IDX_W)) u_prio_cls (
    .vec(cls_hit), .any(cls_any), .idx(cls_idx)
  );
  ttw_prio #(.N(NUM_WIN), .IDX_W(IDX_W)) u_prio_cmp (
    .vec(cmp_hit), .any(cmp_any), .idx(cmp_idx)
  );

  // next state
  ttw_fmt_e         fmt;
  logic             hit_d, fault_d;
  logic [IDX_W-1:0] win_d;
  logic [ST_W-1:0]  status_d;

  assign fmt = ttw_fmt_e'(req_fmt);

  always_comb begin
    hit_d   = 1'b0;
    fault_d = 1'b0;
    win_d   = '0;
    if (fmt == FMT_CLASSIC) begin
      hit_d = cls_any;
      win_d = cls_idx;
    end else begin
      win_d = cmp_idx;
      if (cmp_any) begin
        if (!req_rd && cmp_wp[cmp_idx]) fault_d = 1'b1;
        else                            hit_d   = 1'b1;
      end
    end
    status_d           = '0;
    status_d[ST_TRANS] = hit_d;
    status_d[ST_BERR]  = fault_d;
  end

  // result registers
  logic             valid_q, hit_q, fault_q;
  logic [IDX_W-1:0] win_q;
  logic [ST_W-1:0]  status_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hit_q    <= 1'b0;
      fault_q  <= 1'b0;
      win_q    <= '0;
      status_q <= '0;
    end else if (req_valid) begin
      hit_q    <= hit_d;
      fault_q  <= fault_d;
      win_q    <= win_d;
      status_q <= status_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_hit    = hit_q;
  assign rsp_win    = win_q;
  assign rsp_status = status_q;
  assign rsp_fault  = fault_q;
endmodule

// File: rtl/ttw_matcher_chk.sv
module ttw_matcher_chk #(
  parameter int ST_W     = 16,
  parameter int ST_TRANS = 6,
  parameter int ST_BERR  = 15
) (
  input logic            clk,
  input logic            rst_ns,
  input logic            req_valid,
  input logic            req_fmt,
  input logic [2:0]      req_fc,
  input logic            req_rd,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [ST_W-1:0] rsp_status,
  input logic            rsp_fault
);
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    req_valid |=> rsp_valid);

  assert_valid_drops_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> !rsp_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_valid |=> ($stable(rsp_hit) && $stable(rsp_fault) && $stable(rsp_status)));

  assert_trans_bit_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> (rsp_status[ST_TRANS] == rsp_hit));

  assert_berr_bit_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_valid |-> (rsp_status[ST_BERR] == rsp_fault));

  assert_no_pair_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_fmt && (req_fc[1:0] == 2'b00)) |=> (!rsp_hit && !rsp_fault));

  assert_read_no_fault_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && req_rd) |=> !rsp_fault);

  assert_classic_no_fault_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    (req_valid && !req_fmt) |=> !rsp_fault);
endmodule

bind ttw_matcher ttw_matcher_chk #(
  .ST_W(ST_W), .ST_TRANS(ST_TRANS), .ST_BERR(ST_BERR)
) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .req_valid (req_valid),
  .req_fmt   (req_fmt),
  .req_fc    (req_fc),
  .req_rd    (req_rd),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_status(rsp_status),
  .rsp_fault (rsp_fault)
);

// File: tb/ttw_matcher_tb.sv
module ttw_matcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        req_valid;
  logic        req_fmt;
  logic [31:0] req_addr;
  logic [2:0]  req_fc;
  logic        req_rd;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [0:0]  rsp_win;
  logic [15:0] rsp_status;
  logic        rsp_fault;

  int errs;
  int checks;

  logic [31:0] sh [0:5];

  ttw_matcher u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_fmt(req_fmt), .req_addr(req_addr),
    .req_fc(req_fc), .req_rd(req_rd),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_status(rsp_status), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cls_match(input logic [31:0] r, input logic [7:0] a,
                                     input logic [2:0] fc, input logic rd);
    return r[15] && (((a ^ r[31:24]) & ~r[23:16]) == 8'h00)
                 && (((fc ^ r[6:4]) & ~r[2:0]) == 3'b000)
                 && (r[8] || (rd == r[9]));
  endfunction

  function automatic logic cmp_match(input logic [31:0] r, input logic [7:0] a, input logic s);
    return r[15] && (((a ^ r[31:24]) & ~r[23:16]) == 8'h00)
                 && (r[14] || (r[13] == s));
  endfunction

  // {hit, win, fault, status}
  function automatic logic [18:0] model(input logic fmt, input logic [7:0] a,
                                        input logic [2:0] fc, input logic rd);
    logic m0, m1, hit, fault, win;
    logic [31:0] r0, r1, rw;
    logic [15:0] st;
    if (!fmt) begin
      m0 = cls_match(sh[0], a, fc, rd);
      m1 = cls_match(sh[1], a, fc, rd);
      hit = m0 | m1;
      fault = 1'b0;
    end else begin
      if (fc[0]) begin r0 = sh[2]; r1 = sh[3]; end
      else if (fc[1]) begin r0 = sh[4]; r1 = sh[5]; end
      else begin r0 = '0; r1 = '0; end
      m0 = cmp_match(r0, a, fc[2]);
      m1 = cmp_match(r1, a, fc[2]);
      rw = m0 ? r0 : r1;
      fault = (m0 | m1) && !rd && rw[2];
      hit = (m0 | m1) && !fault;
    end
    win = !m0 && m1;
    st = hit ? 16'h0040 : (fault ? 16'h8000 : 16'h0000);
    return {hit, win, fault, st};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel < 3'd6) sh[sel] = d;
  endtask

  task automatic do_req(input logic fmt, input logic [31:0] addr, input logic [2:0] fc,
                        input logic rd, input string tag);
    logic [18:0] e;
    req_valid = 1'b1; req_fmt = fmt; req_addr = addr; req_fc = fc; req_rd = rd;
    e = model(fmt, addr[31:24], fc, rd);
    @(negedge clk);
    check(tag, {29'd0, rsp_hit, rsp_win, rsp_fault}, {29'd0, e[18:16]});
    check("R8", {16'd0, rsp_status}, {16'd0, e[15:0]});
    check("R3", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic sweep(input logic fmt, input string tag);
    for (int a = 0; a < 256; a++) begin
      for (int f = 0; f < 8; f++) begin
        for (int r = 0; r < 2; r++) begin
          do_req(fmt, {a[7:0], 24'(a * 37 + f * 5 + r)}, f[2:0], r[0], tag);
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [18:0] e;
    logic        held;
    errs = 0; checks = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_fmt = 1'b0; req_addr = '0; req_fc = '0; req_rd = 1'b0;
    for (int i = 0; i < 6; i++) sh[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", {27'd0, rsp_valid, rsp_hit, rsp_win, rsp_fault, 1'b0}, 32'd0);
    check("R1", {16'd0, rsp_status}, 32'd0);
    sweep(1'b0, "R1");
    sweep(1'b1, "R1");

    // R5: 0x40..0x4F, any fc, any direction; window 1 disabled (R4)
    wr(3'd0, 32'h400F_8107);
    wr(3'd1, 32'h400F_0107);
    sweep(1'b0, "R5");

    // R4: disabled catch-all in window 0, window 1 only at 0x77
    wr(3'd0, 32'h00FF_0107);
    wr(3'd1, 32'h7700_8107);
    sweep(1'b0, "R4");

    // R6: fc base 5, fc bit 1 ignored
    wr(3'd0, 32'h1200_8152);
    wr(3'd1, 32'h0000_0000);
    sweep(1'b0, "R6");

    // R7: window 0 reads at 0x12, window 1 writes anywhere
    wr(3'd0, 32'h1200_8207);
    wr(3'd1, 32'h00FF_8007);
    sweep(1'b0, "R7");

    // R9: overlapping windows
    wr(3'd0, 32'h20F0_8107);
    wr(3'd1, 32'h00FF_8107);
    sweep(1'b0, "R9");

    // R2: write and request in the same cycle see the old value
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0;
    do_req(1'b0, 32'h2512_3456, 3'd5, 1'b1, "R2");
    wr_en = 1'b0; sh[0] = 32'h0;
    do_req(1'b0, 32'h2512_3456, 3'd5, 1'b1, "R2");
    // R2: unused selector codes change nothing
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_sel = 3'd7;
    @(negedge clk);
    wr_en = 1'b0;
    do_req(1'b0, 32'h2500_0000, 3'd1, 1'b0, "R2");
    do_req(1'b1, 32'h2500_0000, 3'd1, 1'b0, "R2");

    // R3: outputs hold without a strobe
    do_req(1'b0, 32'h9900_0000, 3'd2, 1'b1, "R3");
    held = rsp_hit;
    req_valid = 1'b0; req_addr = 32'h0; req_fc = 3'd0; req_fmt = 1'b1;
    @(negedge clk);
    check("R3", {31'd0, rsp_valid}, 32'd0);
    check("R3", {31'd0, rsp_hit}, {31'd0, held});
    e = model(1'b0, 8'h99, 3'd2, 1'b1);
    check("R3", {16'd0, rsp_status}, {16'd0, e[15:0]});

    // R10: data pair at 0x40, instruction pair at 0x41
    wr(3'd2, 32'h4000_C000);
    wr(3'd3, 32'h0000_0000);
    wr(3'd4, 32'h4100_C000);
    wr(3'd5, 32'h0000_0000);
    sweep(1'b1, "R10");

    // R11: privilege modes
    wr(3'd2, 32'h100F_8000);
    wr(3'd3, 32'h100F_A000);
    wr(3'd4, 32'h00FF_E000);
    wr(3'd5, 32'h0000_0000);
    sweep(1'b1, "R11");

    // R12: write protection with priority
    wr(3'd2, 32'h807F_C004);
    wr(3'd3, 32'h00FF_C000);
    wr(3'd4, 32'h2000_C004);
    wr(3'd5, 32'h300F_E000);
    sweep(1'b1, "R12");
    // classic with same bit pattern never faults
    wr(3'd0, 32'h00FF_8107);
    sweep(1'b0, "R12");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule